// File: doc/BRIEF.md
# Sequenced Instruction Fetch Unit

This block is the fetch stage of a small processor. A one-hot shift-register sequencer walks through machine cycles. A once-only start flag feeds the sequencer's serial input, so each fetch carries exactly one token. In the first machine cycle the unit puts its instruction pointer on the address output. In the same cycle it pulls low a single active-low enable that serves as both chip select and output enable of an external byte-wide read-only memory. The memory then has one or more whole machine cycles to respond. In the capture cycle the unit loads the memory byte into its instruction register and advances the pointer. It then clears the sequencer and sets the start flag again, so the next fetch begins by itself.

The fetched byte leaves the unit on a valid/ready stream. `instr_valid` rises in the cycle after the instruction register is loaded. It stays high, with `instr` held steady, until a cycle in which `instr_ready` is also high; the transfer happens in that cycle. The consumer applies back-pressure by holding `instr_ready` low. While a byte is waiting, the sequencer stays idle and neither the memory nor the instruction register is touched. If `instr_ready` is tied high, `instr_valid` is a one-cycle pulse and fetches follow each other at a fixed rate.

Top module: `ifetch_seq_unit`

## Requirements
- R1: The reset is synchronous and active high. While `rst` is high, `instr` reads 0x00 and `instr_valid` reads 0. `mem_en_n` is 1, `mem_addr_oe` is 0 and the pointer is cleared to 0. The first clock edge after reset is released starts a fetch from address 0.
- R2: `mem_en_n` is 0 and `mem_addr_oe` is 1 in exactly one cycle per fetch: the address cycle. In that cycle `mem_addr` carries the instruction pointer. In every other cycle `mem_en_n` is 1, `mem_addr_oe` is 0 and `mem_addr` is 0.
- R3: `CAPTURE_STAGE` cycles after the address cycle, the capture cycle ends. At that clock edge `mem_data` is loaded into the instruction register. The register does not change at any other time.
- R4: The pointer advances by one at each capture edge and wraps from 15 to 0. Successive fetches therefore read addresses 0, 1, 2, … in order.
- R5: `instr_valid` goes high in the cycle after the capture edge. It stays high until the first cycle in which `instr_ready` is also high, and it is low in the cycle after that handshake.
- R6: Only one sequencer stage is active at a time. When `instr_ready` is held high, address cycles occur every `CAPTURE_STAGE`+2 cycles.
- R7: While `instr_valid` is high and `instr_ready` is low, no new fetch starts: `mem_en_n` stays 1 and `instr` holds its value.
- R8: After a handshake, the next cycle is the address cycle of the following fetch. A fetch that was stalled for s cycles therefore extends the spacing between address cycles by exactly s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory address; carries the instruction pointer in the address cycle, 0 otherwise |
| mem_addr_oe | output | 1 | High when the unit drives the address bus |
| mem_en_n | output | 1 | Combined chip and output enable of the memory, active low |
| mem_data | input | DATA_W | Byte returned by the memory |
| instr | output | DATA_W | Instruction register contents |
| instr_valid | output | 1 | Instruction register holds a byte that has not yet been taken |
| instr_ready | input | 1 | Consumer accepts the byte |

## Verification
Two things can land on the same clock edge: the consumer's handshake and the start of the next fetch. The bench provokes this by raising `instr_ready` in the last stall cycle, for stall lengths from zero to four. It judges the result by the cycle count between address cycles, which must be the base period plus the stall. The capture edge also advances the pointer across the wrap from 15 to 0. The bench judges that edge by the address order and by the byte in `instr` after the wrap.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  // Control outputs of the sequencer, one bit per job.
  typedef struct packed {
    logic addr_phase;  // drive address and enable memory
    logic capture;     // load instruction register, step pointer, restart
  } ifu_ctl_t;

endpackage

// File: rtl/ifu_sequencer.sv
module ifu_sequencer
  import ifu_pkg::*;
#(
  parameter int NUM_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  output ifu_ctl_t ctl
);

  logic [NUM_STAGES-1:0] stages;
  logic                  armed;   // once-only start flag, feeds serial input

  always_ff @(posedge clk) begin
    if (rst || ctl.capture) begin
      stages <= '0;
      armed  <= 1'b1;
    end else if (!hold) begin
      stages <= {stages[NUM_STAGES-2:0], armed};
      armed  <= 1'b0;
    end
  end

  always_comb begin
    ctl.addr_phase = stages[0];
    ctl.capture    = stages[NUM_STAGES-1];
  end

  a_r6_single_token: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stages));

  a_r6_armed_only_idle: assert property (@(posedge clk) disable iff (rst)
    armed |-> (stages == '0));

  a_r8_restart_after_capture: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |=> (armed && stages == '0));

endmodule

// File: rtl/ifu_pointer.sv
module ifu_pointer #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] ip
);

  always_ff @(posedge clk) begin
    if (rst)       ip <= '0;
    else if (step) ip <= ip + 1'b1;
  end

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (step && ip == '1) |=> (ip == '0));

  a_r4_still_without_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ip));

endmodule

// File: rtl/ifu_ireg.sv
module ifu_ireg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ready,
  output logic [DATA_W-1:0] ir,
  output logic              valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir    <= '0;
      valid <= 1'b0;
    end else begin
      if (load) ir <= din;
      if (load)       valid <= 1'b1;
      else if (ready) valid <= 1'b0;
    end
  end

  a_r5_valid_after_load: assert property (@(posedge clk) disable iff (rst)
    load |=> valid);

  a_r7_hold_under_backpressure: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(ir)));

endmodule

// File: rtl/ifetch_seq_unit.sv
module ifetch_seq_unit
  import ifu_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter int CAPTURE_STAGE = 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_oe,
  output logic              mem_en_n,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] instr,
  output logic              instr_valid,
  input  logic              instr_ready
);

  localparam int NUM_STAGES = CAPTURE_STAGE + 1;

  ifu_ctl_t          ctl;
  logic [ADDR_W-1:0] ip;
  logic              stall;

  assign stall = instr_valid && !instr_ready;

  ifu_sequencer #(.NUM_STAGES(NUM_STAGES)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .hold (stall),
    .ctl  (ctl)
  );

  ifu_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .step (ctl.capture),
    .ip   (ip)
  );

  ifu_ireg #(.DATA_W(DATA_W)) u_ir (
    .clk   (clk),
    .rst   (rst),
    .load  (ctl.capture),
    .din   (mem_data),
    .ready (instr_ready),
    .ir    (instr),
    .valid (instr_valid)
  );

  always_comb begin
    mem_addr_oe = ctl.addr_phase;
    mem_en_n    = ~ctl.addr_phase;
    mem_addr    = ctl.addr_phase ? ip : '0;
  end

  a_r2_single_address_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_addr_oe |=> !mem_addr_oe);

  a_r2_enable_matches_bus: assert property (@(posedge clk) disable iff (rst)
    (mem_en_n == !mem_addr_oe));

  a_r7_no_fetch_while_stalled: assert property (@(posedge clk) disable iff (rst)
    stall |-> mem_en_n);

  a_r8_fetch_after_handshake: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready) |=> !mem_en_n);

endmodule

// File: tb/ifetch_seq_unit_tb.sv
`timescale 1ns/1ps
module ifetch_seq_unit_tb;

  localparam int AW     = 4;
  localparam int DW     = 8;
  localparam int CAP    = 1;
  localparam int PERIOD = CAP + 2;
  localparam int NVEC   = 20;
  // stall cycles applied to each fetch, walked in order
  localparam int STALL_TAB [NVEC] = '{0, 0, 1, 0, 0, 3, 0, 2, 0, 0,
                                      0, 1, 0, 0, 4, 0, 0, 0, 2, 0};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_addr_oe;
  logic          mem_en_n;
  logic [DW-1:0] mem_q = '0;
  logic [DW-1:0] instr;
  logic          instr_valid;
  logic          instr_ready = 1'b1;

  int     checks = 0;
  int     errors = 0;
  longint cyc    = 0;
  bit     done   = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] rom_byte(input int a);
    return DW'((a * 29 + 7) % 256);
  endfunction

  // memory model: registered read while enabled, holds its output otherwise
  always @(posedge clk) if (!mem_en_n) mem_q <= rom_byte(int'(mem_addr));

  ifetch_seq_unit #(.ADDR_W(AW), .DATA_W(DW), .CAPTURE_STAGE(CAP)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .mem_addr    (mem_addr),
    .mem_addr_oe (mem_addr_oe),
    .mem_en_n    (mem_en_n),
    .mem_data    (mem_q),
    .instr       (instr),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint last_a = 0;
    int     prev_s = 0;

    // R1: state while reset is held
    repeat (3) @(negedge clk);
    chk(instr == 8'h00, "R1 instr in reset", instr, 0);
    chk(!instr_valid, "R1 valid in reset", instr_valid, 0);
    chk(mem_en_n && !mem_addr_oe, "R1 memory disabled in reset", mem_en_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_en_n, "R1 first fetch on first edge", mem_en_n, 0);

    for (int i = 0; i < NVEC; i++) begin
      int s = STALL_TAB[i];
      int guard = 0;
      while (mem_en_n && guard < 20) begin @(negedge clk); guard++; end
      chk(mem_addr_oe, "R2 oe in address cycle", mem_addr_oe, 1);
      chk(int'(mem_addr) == i % 16, "R4 address order", mem_addr, i % 16);
      if (i > 0) begin
        chk(!instr_valid, "R5 valid drops after handshake", instr_valid, 0);
        if (prev_s > 0)
          chk(cyc - last_a == PERIOD + prev_s, "R8 spacing after stall", cyc - last_a, PERIOD + prev_s);
        else
          chk(cyc - last_a == PERIOD, "R6 fetch period", cyc - last_a, PERIOD);
      end
      last_a = cyc;
      @(negedge clk);
      chk(mem_en_n && !mem_addr_oe && mem_addr == '0, "R2 idle bus", mem_addr_oe, 0);
      chk(!instr_valid, "R5 no valid before capture", instr_valid, 0);
      repeat (CAP - 1) @(negedge clk);
      instr_ready = (s == 0);
      @(negedge clk);
      chk(instr_valid, "R5 valid after capture", instr_valid, 1);
      chk(instr == rom_byte(i % 16), "R3 captured byte", instr, rom_byte(i % 16));
      for (int k = 0; k < s; k++) begin
        @(negedge clk);
        chk(instr_valid && mem_en_n, "R7 stalled no fetch", mem_en_n, 1);
        chk(instr == rom_byte(i % 16), "R7 instr held", instr, rom_byte(i % 16));
      end
      instr_ready = 1'b1;
      prev_s = s;
    end

    // R1: reset in the middle of a stall, then restart from address 0
    instr_ready = 1'b0;
    begin
      int guard = 0;
      while (!instr_valid && guard < 20) begin @(negedge clk); guard++; end
    end
    rst = 1'b1;
    @(negedge clk);
    chk(instr == 8'h00 && !instr_valid, "R1 reset clears instr", instr, 0);
    chk(mem_en_n, "R1 reset disables memory", mem_en_n, 1);
    rst = 1'b0;
    instr_ready = 1'b1;
    @(negedge clk);
    chk(!mem_en_n && mem_addr == '0, "R1 restart at address 0", mem_addr, 0);
    repeat (CAP + 1) @(negedge clk);
    chk(instr_valid && instr == rom_byte(0), "R3 first byte after reset", instr, rom_byte(0));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule